// File: doc/BRIEF.md
# Floating-Point Compare and Condition Flags

This block compares two IEEE-754 operands, in either single or double precision, under one of sixteen predicate codes. The one-bit outcome is stored in a bank of eight condition flags. A compare is launched by a one-cycle valid strobe. The strobe carries the operands, a precision select, the predicate code and the index of the flag to update. The flag and an invalid-operation indication are registered on the next clock edge.

The predicate code is read as four select bits:
- bit 0 makes an unordered pair (either operand a NaN) true;
- bit 1 admits equality;
- bit 2 admits less-than;
- bit 3 marks the signalling form, which raises invalid on any NaN rather than only on a signalling NaN.

Two independent read ports serve the consumers of the flags. One serves branch logic and one serves conditional-move logic. Each port selects a flag and compares it against a requested truth value. The ports are combinational from the flag bank.

Top module: `fp_cond_unit`

## Requirements
- R1: While reset (active low) is asserted, all eight flags and invalid_o are 0.
- R2: When either operand is a NaN (all-ones exponent, nonzero fraction), the result is 1 for odd predicate codes and 0 for even codes.
- R3: Codes 0 and 8 always give 0. Codes 1 and 9 give 1 only for an unordered pair.
- R4: For ordered operands, codes 2, 3, 10 and 11 give 1 exactly when the operands are equal, with +0 equal to -0.
- R5: For ordered operands, codes 4, 5, 12 and 13 give 1 exactly when A < B. This follows sign-magnitude ordering, so a more negative value is smaller and zeros of either sign are not less than each other.
- R6: For ordered operands, codes 6, 7, 14 and 15 give 1 exactly when A <= B.
- R7: invalid_o is 1 in the cycle after a valid strobe when either of the following holds, and 0 otherwise:
  - the code is 8 to 15 and either operand is any NaN;
  - the code is 0 to 7 and either operand is a signalling NaN (top fraction bit clear).
- R8: The result of a strobed compare appears on flag cc_idx_i one clock edge after the strobe. Other flags are unchanged, and without a strobe no flag changes.
- R9: With is_double_i = 0, only op_a_i[31:0] and op_b_i[31:0] are compared, as single precision. With is_double_i = 1, all 64 bits are compared as double precision.
- R10: br_taken_o is 1 exactly when flag br_sel_i equals br_want_i. mv_take_o is 1 exactly when flag mv_sel_i equals mv_want_i. The two ports select independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp_valid_i | input | 1 | Compare strobe |
| is_double_i | input | 1 | 1 = double precision, 0 = single precision |
| pred_i | input | 4 | Predicate code |
| cc_idx_i | input | 3 | Destination flag index |
| op_a_i | input | 64 | Operand A (single uses bits 31:0) |
| op_b_i | input | 64 | Operand B (single uses bits 31:0) |
| br_sel_i | input | 3 | Branch port flag select |
| br_want_i | input | 1 | Branch port requested truth value |
| mv_sel_i | input | 3 | Move port flag select |
| mv_want_i | input | 1 | Move port requested truth value |
| cc_flags_o | output | 8 | Condition flag bank |
| invalid_o | output | 1 | Invalid-operation indication |
| br_taken_o | output | 1 | Branch port match |
| mv_take_o | output | 1 | Move port match |

## Verification
The compare path is tried with the following operand patterns:
- Equal and unequal positives separate equality from ordering.
- Pairs of negatives show whether the magnitude order is reversed for sign-magnitude values.
- +0 against -0 catches a raw bit comparison.
- Infinity against a finite value checks the all-ones exponent without a fraction.
- Quiet and signalling NaNs under quiet and signalling codes separate the result's parity rule from the invalid rule.

Single-precision vectors with garbage in the upper word show that the precision select drops those bits. Sweeping both read ports over every flag and both truth values shows that the two selects are independent.

// File: rtl/fpcc_pkg.sv
package fpcc_pkg;
  localparam int unsigned OP_W     = 64;
  localparam int unsigned MAG_W    = OP_W - 1;
  localparam int unsigned SP_EXP_W = 8;
  localparam int unsigned SP_FRC_W = 23;
  localparam int unsigned DP_EXP_W = 11;
  localparam int unsigned DP_FRC_W = 52;
  localparam int unsigned CC_NUM   = 8;
  localparam int unsigned CC_IDX_W = $clog2(CC_NUM);
  localparam int unsigned PRED_W   = 4;

  // predicate select bit positions
  localparam int unsigned PB_UNORD = 0;
  localparam int unsigned PB_EQ    = 1;
  localparam int unsigned PB_LT    = 2;
  localparam int unsigned PB_SIG   = 3;

  typedef struct packed {
    logic             nan;
    logic             snan;
    logic             zero;
    logic             sign;
    logic [MAG_W-1:0] mag;
  } fp_class_t;
endpackage

// File: rtl/fpcc_classify.sv
module fpcc_classify
  import fpcc_pkg::*;
#(
  parameter int unsigned EXP_W = 8,
  parameter int unsigned FRC_W = 23,
  localparam int unsigned W = EXP_W + FRC_W + 1
) (
  input  logic [W-1:0] val_i,
  output fp_class_t    cls_o
);
  logic [EXP_W-1:0] exp_f;
  logic [FRC_W-1:0] frc_f;

  assign exp_f = val_i[W-2 -: EXP_W];
  assign frc_f = val_i[FRC_W-1:0];

  always_comb begin
    cls_o          = '0;
    cls_o.nan      = (&exp_f) && (|frc_f);
    cls_o.snan     = (&exp_f) && (|frc_f) && !frc_f[FRC_W-1];
    cls_o.zero     = ~|val_i[W-2:0];
    cls_o.sign     = val_i[W-1];
    cls_o.mag[W-2:0] = val_i[W-2:0];
  end
endmodule

// File: rtl/fpcc_compare.sv
module fpcc_compare
  import fpcc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chk_en_i,
  input  fp_class_t         a_i,
  input  fp_class_t         b_i,
  input  logic [PRED_W-1:0] pred_i,
  output logic              result_o,
  output logic              invalid_o
);
  logic unord, both_zero, eq, lt;

  always_comb begin
    unord     = a_i.nan | b_i.nan;
    both_zero = a_i.zero & b_i.zero;
    eq        = both_zero | ((a_i.sign == b_i.sign) && (a_i.mag == b_i.mag));
    if (both_zero)               lt = 1'b0;
    else if (a_i.sign != b_i.sign) lt = a_i.sign;
    else if (!a_i.sign)          lt = a_i.mag < b_i.mag;
    else                         lt = a_i.mag > b_i.mag;

    if (unord) result_o = pred_i[PB_UNORD];
    else       result_o = (pred_i[PB_EQ] & eq) | (pred_i[PB_LT] & lt);

    invalid_o = pred_i[PB_SIG] ? unord : (a_i.snan | b_i.snan);
  end

  // R2: unordered pair follows code parity
  p_unord_parity_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_en_i && (a_i.nan || b_i.nan)) |-> (result_o == pred_i[0]));

  // R5: ordered operands are never both equal and less
  p_eq_lt_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_en_i && !unord) |-> !(eq && lt));

  // R4: zeros of either sign compare equal
  p_zero_equal_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_en_i && a_i.zero && b_i.zero) |-> (eq && !lt));
endmodule

// File: rtl/fpcc_flag_bank.sv
module fpcc_flag_bank
  import fpcc_pkg::*;
#(
  parameter int unsigned NUM_RD = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en_i,
  input  logic [CC_IDX_W-1:0] wr_idx_i,
  input  logic                wr_val_i,
  input  logic [CC_IDX_W-1:0] rd_sel_i  [NUM_RD],
  input  logic                rd_want_i [NUM_RD],
  output logic                rd_hit_o  [NUM_RD],
  output logic [CC_NUM-1:0]   flags_o
);
  logic [CC_NUM-1:0] flags_q, flags_d;

  for (genvar f = 0; f < CC_NUM; f++) begin : g_flag
    logic sel_en;
    assign sel_en = wr_en_i && (wr_idx_i == CC_IDX_W'(f));
    always_comb begin
      flags_d[f] = flags_q[f];
      if (sel_en) flags_d[f] = wr_val_i;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flags_q[f] <= 1'b0;
      else        flags_q[f] <= flags_d[f];
    end
  end

  for (genvar r = 0; r < NUM_RD; r++) begin : g_rd
    assign rd_hit_o[r] = (flags_q[rd_sel_i[r]] == rd_want_i[r]);
  end

  assign flags_o = flags_q;

  // R8: no strobe, no flag change
  p_idle_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en_i |=> $stable(flags_q));

  // R8: strobed value lands in the indexed flag
  p_write_lands_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i |=> (flags_q[$past(wr_idx_i)] == $past(wr_val_i)));
endmodule

// File: rtl/fp_cond_unit.sv
module fp_cond_unit
  import fpcc_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cmp_valid_i,
  input  logic                is_double_i,
  input  logic [PRED_W-1:0]   pred_i,
  input  logic [CC_IDX_W-1:0] cc_idx_i,
  input  logic [OP_W-1:0]     op_a_i,
  input  logic [OP_W-1:0]     op_b_i,
  input  logic [CC_IDX_W-1:0] br_sel_i,
  input  logic                br_want_i,
  input  logic [CC_IDX_W-1:0] mv_sel_i,
  input  logic                mv_want_i,
  output logic [CC_NUM-1:0]   cc_flags_o,
  output logic                invalid_o,
  output logic                br_taken_o,
  output logic                mv_take_o
);
  localparam int unsigned SP_W = SP_EXP_W + SP_FRC_W + 1;

  logic [OP_W-1:0] opnd [2];
  fp_class_t       cls  [2];
  logic            cmp_res, cmp_inv;
  logic            inv_d, inv_q;

  assign opnd[0] = op_a_i;
  assign opnd[1] = op_b_i;

  for (genvar k = 0; k < 2; k++) begin : g_opnd
    fp_class_t c_sp, c_dp;
    fpcc_classify #(.EXP_W(SP_EXP_W), .FRC_W(SP_FRC_W)) u_cls_sp (
      .val_i (opnd[k][SP_W-1:0]),
      .cls_o (c_sp)
    );
    fpcc_classify #(.EXP_W(DP_EXP_W), .FRC_W(DP_FRC_W)) u_cls_dp (
      .val_i (opnd[k]),
      .cls_o (c_dp)
    );
    assign cls[k] = is_double_i ? c_dp : c_sp;
  end

  fpcc_compare u_cmp (
    .clk       (clk),
    .rst_n     (rst_n),
    .chk_en_i  (cmp_valid_i),
    .a_i       (cls[0]),
    .b_i       (cls[1]),
    .pred_i    (pred_i),
    .result_o  (cmp_res),
    .invalid_o (cmp_inv)
  );

  logic [CC_IDX_W-1:0] rd_sel  [2];
  logic                rd_want [2];
  logic                rd_hit  [2];

  assign rd_sel[0]  = br_sel_i;
  assign rd_want[0] = br_want_i;
  assign rd_sel[1]  = mv_sel_i;
  assign rd_want[1] = mv_want_i;

  fpcc_flag_bank #(.NUM_RD(2)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en_i   (cmp_valid_i),
    .wr_idx_i  (cc_idx_i),
    .wr_val_i  (cmp_res),
    .rd_sel_i  (rd_sel),
    .rd_want_i (rd_want),
    .rd_hit_o  (rd_hit),
    .flags_o   (cc_flags_o)
  );

  assign br_taken_o = rd_hit[0];
  assign mv_take_o  = rd_hit[1];

  always_comb begin
    inv_d = 1'b0;
    if (cmp_valid_i) inv_d = cmp_inv;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) inv_q <= 1'b0;
    else        inv_q <= inv_d;
  end

  assign invalid_o = inv_q;

  // R7: no strobe, no invalid in the next cycle
  p_invalid_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !cmp_valid_i |=> !invalid_o);

  // R7: quiet codes without a signalling NaN never raise invalid
  p_invalid_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_valid_i && !pred_i[3] && !cls[0].snan && !cls[1].snan) |=> !invalid_o);
endmodule

// File: tb/fp_cond_unit_tb.sv
`timescale 1ns/1ps
module fp_cond_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmp_valid_i, is_double_i;
  logic [3:0]  pred_i;
  logic [2:0]  cc_idx_i, br_sel_i, mv_sel_i;
  logic [63:0] op_a_i, op_b_i;
  logic        br_want_i, mv_want_i;
  logic [7:0]  cc_flags_o;
  logic        invalid_o, br_taken_o, mv_take_o;

  always #10 clk = ~clk;

  fp_cond_unit u_dut (.*);

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  typedef struct packed {
    logic        dbl;
    logic [3:0]  pred;
    logic [63:0] a;
    logic [63:0] b;
    logic        res;
    logic        inv;
  } vec_t;

  localparam logic [63:0] S1 = 64'h3F800000, S2 = 64'h40000000;
  localparam logic [63:0] SM1 = 64'hBF800000, SM2 = 64'hC0000000;
  localparam logic [63:0] SZ = 64'h0, SNZ = 64'h80000000;
  localparam logic [63:0] SQN = 64'h7FC00000, SSN = 64'h7F800001, SINF = 64'h7F800000;
  localparam logic [63:0] D1 = 64'h3FF0000000000000, D2 = 64'h4000000000000000;
  localparam logic [63:0] DM2 = 64'hC000000000000000, DNZ = 64'h8000000000000000;
  localparam logic [63:0] DQN = 64'h7FF8000000000000, DSN = 64'h7FF0000000000001;
  localparam int NV = 25;

  localparam vec_t VECS [NV] = '{
    {1'b0, 4'd2,  S1,  S1,  1'b1, 1'b0},   // R4 equal
    {1'b0, 4'd2,  S1,  S2,  1'b0, 1'b0},   // R4 unequal
    {1'b0, 4'd2,  SZ,  SNZ, 1'b1, 1'b0},   // R4 +0 == -0
    {1'b0, 4'd4,  SM2, SM1, 1'b1, 1'b0},   // R5 negatives
    {1'b0, 4'd4,  SM1, SM2, 1'b0, 1'b0},   // R5 negatives reversed
    {1'b0, 4'd4,  SM1, S1,  1'b1, 1'b0},   // R5 mixed sign
    {1'b0, 4'd6,  S2,  S2,  1'b1, 1'b0},   // R6 equal
    {1'b0, 4'd6,  SINF,S2,  1'b0, 1'b0},   // R6 infinity
    {1'b0, 4'd3,  SQN, S1,  1'b1, 1'b0},   // R2 odd code, NaN
    {1'b0, 4'd2,  SQN, S1,  1'b0, 1'b0},   // R2 even code, NaN
    {1'b0, 4'd2,  SSN, S1,  1'b0, 1'b1},   // R7 sNaN on quiet code
    {1'b0, 4'd10, SQN, S1,  1'b0, 1'b1},   // R7 qNaN on signalling code
    {1'b0, 4'd9,  S1,  S2,  1'b0, 1'b0},   // R3 code 9 ordered
    {1'b0, 4'd9,  S1,  SQN, 1'b1, 1'b1},   // R3 code 9 unordered
    {1'b0, 4'd0,  S1,  S1,  1'b0, 1'b0},   // R3 code 0
    {1'b0, 4'd8,  S1,  S1,  1'b0, 1'b0},   // R3 code 8
    {1'b0, 4'd1,  SQN, SQN, 1'b1, 1'b0},   // R3 code 1 unordered
    {1'b1, 4'd4,  DM2, D1,  1'b1, 1'b0},   // R9 double lt
    {1'b1, 4'd7,  DQN, D1,  1'b1, 1'b0},   // R9 double NaN
    {1'b1, 4'd2,  DSN, D1,  1'b0, 1'b1},   // R9 double sNaN
    {1'b1, 4'd12, D1,  D2,  1'b1, 1'b0},   // R5 double
    {1'b0, 4'd2,  {32'hFFFFFFFF, 32'h3F800000}, S1, 1'b1, 1'b0}, // R9 upper ignored
    {1'b1, 4'd4,  64'h0, DNZ, 1'b0, 1'b0}, // R5 zeros not less
    {1'b0, 4'd13, S1,  S2,  1'b1, 1'b0},   // R5 code 13
    {1'b0, 4'd15, SSN, S1,  1'b1, 1'b1}    // R6/R7 code 15
  };

  logic [7:0] model;

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cmp_valid_i = 1'b0; is_double_i = 1'b0; pred_i = '0;
    cc_idx_i = '0; op_a_i = '0; op_b_i = '0;
    br_sel_i = '0; mv_sel_i = '0; br_want_i = 1'b0; mv_want_i = 1'b0;
    model = '0;
    repeat (2) @(negedge clk);
    chk("R1 flags in reset", 64'(cc_flags_o), 64'h0);
    chk("R1 invalid in reset", 64'(invalid_o), 64'h0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      cmp_valid_i = 1'b1;
      is_double_i = VECS[i].dbl;
      pred_i      = VECS[i].pred;
      op_a_i      = VECS[i].a;
      op_b_i      = VECS[i].b;
      cc_idx_i    = 3'(i % 8);
      @(negedge clk);
      model[i % 8] = VECS[i].res;
      $display("vector %0d", i);
      chk("R2-R6 result", 64'(cc_flags_o[i % 8]), 64'(VECS[i].res));
      chk("R7 invalid", 64'(invalid_o), 64'(VECS[i].inv));
    end
    chk("R8 whole bank", 64'(cc_flags_o), 64'(model));

    // R8: idle cycles with changing inputs leave flags alone; R7 invalid drops
    cmp_valid_i = 1'b0;
    pred_i = 4'd9; op_a_i = SQN; op_b_i = SQN; cc_idx_i = 3'd2; is_double_i = 1'b0;
    @(negedge clk);
    chk("R7 invalid low without strobe", 64'(invalid_o), 64'h0);
    @(negedge clk);
    chk("R8 no strobe no change", 64'(cc_flags_o), 64'(model));

    // R8: single write touches only its index
    cmp_valid_i = 1'b1; cc_idx_i = 3'd3; pred_i = 4'd1;
    op_a_i = model[3] ? S1 : SQN; op_b_i = S1;
    @(negedge clk);
    cmp_valid_i = 1'b0;
    model[3] = ~model[3];
    chk("R8 only indexed flag", 64'(cc_flags_o), 64'(model));

    // R10: both read ports, all selects, both truth values
    for (int s = 0; s < 8; s++) begin
      for (int w = 0; w < 2; w++) begin
        br_sel_i = 3'(s); br_want_i = w[0];
        mv_sel_i = 3'(7 - s); mv_want_i = ~w[0];
        #1;
        chk("R10 branch port", 64'(br_taken_o), 64'(model[s] == w[0]));
        chk("R10 move port", 64'(mv_take_o), 64'(model[7 - s] == ~w[0]));
      end
    end

    // R1: reset mid-run clears bank
    @(negedge clk);
    rst_n = 1'b0;
    #2;
    chk("R1 reset clears bank", 64'(cc_flags_o), 64'h0);
    chk("R1 reset clears invalid", 64'(invalid_o), 64'h0);
    @(negedge clk);
    rst_n = 1'b1;

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule